// File: doc/BRIEF.md
# Cascaded DAC Frame Writer

This block is the host side of a write path to a string of up to eight serially cascaded 10-bit digital-to-analog converters. The devices share one chip select and one serial clock. The data output of each device feeds the data input of the next one. On a start request the block takes one 10-bit code per device and a device count. It forms a 16-bit word for each device: four leading filler bits, the code with its most significant bit first, and two trailing zero bits. It then shifts all the words out in a single chip-select-low window, using SPI mode 0. The word for the device at the far end of the chain goes first. Chip select then rises while the clock is low, and every device loads its code at that moment.

The serial clock is derived from the system clock by a state machine whose phase lengths are counted in system cycles. `ST_IDLE` waits for start. `ST_LEAD` pulls chip select low and holds the clock low for the low-phase length. `ST_HIGH` and `ST_LOW` alternate once per bit. After the last bit, `ST_LOW` goes to `ST_DESEL` instead of `ST_HIGH`. `ST_DESEL` holds chip select high for the programmed gap and then returns to `ST_IDLE` with a one-cycle done pulse. The other transitions are `ST_IDLE`→`ST_LEAD` on start, `ST_LEAD`→`ST_HIGH` and `ST_HIGH`→`ST_LOW` when the phase timer expires, and `ST_LOW`→`ST_HIGH` while bits remain. A readback option samples the data returned by the far end of the chain. It reports whether that data matches the previous frame.

Top module: `dac_chain_writer`

## Requirements
- R1: While reset is held and after it is released with no start, cs_n=1, sclk=0, sdo=0, busy=0, done=0 and mismatch=0.
- R2: Each device word is 16 bits sent most significant bit first: bits 15..12 are 0, bits 11..2 carry the 10-bit code with code bit 9 in bit 11, and bits 1..0 are 0.
- R3: All words of one request are sent in exactly one cs_n-low window holding 16×N rising sclk edges. Word k (k=0 first) carries the code in slot N-1-k of `codes`, where slot d is bits [10d+9:10d] and slot 0 is the device nearest the controller. A dev_count of 0 is treated as 1, and a value above 8 is treated as 8.
- R4: While cs_n is low, each sclk high phase lasts at least HI_CYC system cycles and each sclk low phase before a rising edge lasts at least LO_CYC cycles. sdo does not change at any edge where sclk is sampled high.
- R5: cs_n changes only at an edge where sclk is low both before and after, and sclk is low whenever cs_n is high.
- R6: After a frame, cs_n stays high for at least max(desel_min,1) cycles before it can fall again. done is a single-cycle pulse that appears when that time ends, with busy already low.
- R7: busy is high from the cycle after a start accepted in idle until done. A start while busy is ignored: it alters neither the frame in flight nor starts another one.
- R8: With readback_en set at start, sdi is sampled at each edge where sclk rises, using the value before that edge. At the end of the frame, mismatch becomes 1 only if the previous frame had the same device count and the N×16 sampled bits differ from the bits that frame sent. Otherwise it becomes 0. A frame without readback leaves mismatch unchanged.
- R9: From the edge that accepts start to the edge after which done is high takes exactly LO_CYC + 16·N·(HI_CYC+LO_CYC) + max(desel_min,1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request a frame (taken only in idle) |
| dev_count | input | 4 | Number of devices in the chain |
| codes | input | 80 | 10-bit code per device, slot 0 nearest |
| desel_min | input | 8 | Minimum chip-select-high time in cycles |
| readback_en | input | 1 | Compare returned data for this frame |
| sdi | input | 1 | Data returned by the far end of the chain |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data to the first device |
| cs_n | output | 1 | Shared active-low chip select |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse after the deselect gap |
| mismatch | output | 1 | Readback result of the last readback frame |

## Verification
The bound checker watches the signalling rules on every cycle: the minimum high and low phase lengths, sdo holding still while the clock is high, chip select moving only with the clock low, and the clock staying low while deselected. It also checks that done is a single-cycle pulse in idle, that an accepted start raises busy, and that mismatch changes only together with done. Only the directed scenarios can show that the bit stream has the right word layout and device order, that the count clamps, the exact start-to-done latency and the programmed gap are right, that a start during a frame has no effect, and that readback flags a corrupted chain while still accepting a clean one.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;

    localparam int WORD_W = 16;
    localparam int CODE_W = 10;
    localparam int PAD_HI = 4;
    localparam int PAD_LO = WORD_W - PAD_HI - CODE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_DESEL
    } ctl_state_t;

    // Filler bits and sub-LSB bits are driven to zero.
    function automatic logic [WORD_W-1:0] pack_word(input logic [CODE_W-1:0] c);
        return {{PAD_HI{1'b0}}, c, {PAD_LO{1'b0}}};
    endfunction

endpackage

// File: rtl/sclk_phase_timer.sv
module sclk_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // A load of value V makes the phase last exactly V cycles (V >= 1).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/chain_frame_packer.sv
module chain_frame_packer
    import dac_chain_pkg::*;
#(
    parameter int MAX_DEV = 8,
    parameter int CNT_W   = $clog2(MAX_DEV + 1),
    parameter int FRAME_W = MAX_DEV * WORD_W
) (
    input  logic [MAX_DEV*CODE_W-1:0] codes,
    input  logic [CNT_W-1:0]          count,
    output logic [FRAME_W-1:0]        frame
);

    // Slot k (from the top) goes out k-th; it carries device count-1-k,
    // so the farthest device's word leads the frame.
    for (genvar k = 0; k < MAX_DEV; k++) begin : g_slot
        logic [WORD_W-1:0] slot;

        always_comb begin
            slot = '0;
            for (int d = 0; d < MAX_DEV; d++) begin
                if ((k < int'(count)) && (d == int'(count) - 1 - k)) begin
                    slot = pack_word(codes[d*CODE_W +: CODE_W]);
                end
            end
        end

        assign frame[FRAME_W-1-k*WORD_W -: WORD_W] = slot;
    end

endmodule

// File: rtl/chain_readback_check.sv
module chain_readback_check #(
    parameter int FRAME_W = 128,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             bit_strobe,
    input  logic             sdo_bit,
    input  logic             sdi_bit,
    input  logic             frame_end,
    input  logic             rb_en,
    input  logic [CNT_W-1:0] count,
    output logic             mismatch
);

    logic [FRAME_W-1:0] tx_log;
    logic [FRAME_W-1:0] rx_log;
    logic [FRAME_W-1:0] prev_tx;
    logic [CNT_W-1:0]   prev_cnt;
    logic               prev_valid;

    // Both logs are right-aligned, so equal counts compare bit for bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_log <= '0;
            rx_log <= '0;
        end else if (frame_start) begin
            tx_log <= '0;
            rx_log <= '0;
        end else if (bit_strobe) begin
            tx_log <= {tx_log[FRAME_W-2:0], sdo_bit};
            rx_log <= {rx_log[FRAME_W-2:0], sdi_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_tx    <= '0;
            prev_cnt   <= '0;
            prev_valid <= 1'b0;
            mismatch   <= 1'b0;
        end else if (frame_end) begin
            if (rb_en) begin
                mismatch <= prev_valid && (prev_cnt == count) && (rx_log != prev_tx);
            end
            prev_tx    <= tx_log;
            prev_cnt   <= count;
            prev_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/dac_chain_writer.sv
module dac_chain_writer
    import dac_chain_pkg::*;
#(
    parameter int MAX_DEV = 8,
    parameter int HI_CYC  = 4,
    parameter int LO_CYC  = 4,
    parameter int GAP_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [$clog2(MAX_DEV+1)-1:0] dev_count,
    input  logic [MAX_DEV*CODE_W-1:0]    codes,
    input  logic [GAP_W-1:0]             desel_min,
    input  logic                         readback_en,
    input  logic                         sdi,
    output logic                         sclk,
    output logic                         sdo,
    output logic                         cs_n,
    output logic                         busy,
    output logic                         done,
    output logic                         mismatch
);

    localparam int CNT_W   = $clog2(MAX_DEV + 1);
    localparam int FRAME_W = MAX_DEV * WORD_W;
    localparam int BIT_W   = $clog2(FRAME_W + 1);
    localparam int HI_EFF  = (HI_CYC < 1) ? 1 : HI_CYC;
    localparam int LO_EFF  = (LO_CYC < 1) ? 1 : LO_CYC;
    localparam int PH_MAX  = (HI_EFF > LO_EFF) ? HI_EFF : LO_EFF;
    localparam int PH_W    = $clog2(PH_MAX + 1);
    localparam int TMR_W   = (GAP_W > PH_W) ? GAP_W : PH_W;

    ctl_state_t         state, state_nxt;
    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] frame_img;
    logic [BIT_W-1:0]   bits_left;
    logic [GAP_W-1:0]   gap_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               rb_q;
    logic [CNT_W-1:0]   cnt_eff;
    logic [GAP_W-1:0]   gap_eff;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_done;
    logic               sclk_q, cs_n_q, done_q;
    logic               accept, rise_edge, frame_end;

    // Device count clamped into 1..MAX_DEV, gap at least one cycle.
    always_comb begin
        if (dev_count == '0) begin
            cnt_eff = CNT_W'(1);
        end else if (int'(dev_count) > MAX_DEV) begin
            cnt_eff = CNT_W'(MAX_DEV);
        end else begin
            cnt_eff = dev_count;
        end
        gap_eff = (desel_min == '0) ? GAP_W'(1) : desel_min;
    end

    chain_frame_packer #(
        .MAX_DEV (MAX_DEV),
        .CNT_W   (CNT_W),
        .FRAME_W (FRAME_W)
    ) u_pack (
        .codes (codes),
        .count (cnt_eff),
        .frame (frame_img)
    );

    sclk_phase_timer #(
        .W (TMR_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start)    state_nxt = ST_LEAD;
            ST_LEAD:  if (tmr_done) state_nxt = ST_HIGH;
            ST_HIGH:  if (tmr_done) state_nxt = ST_LOW;
            ST_LOW:   if (tmr_done) state_nxt = (bits_left == '0) ? ST_DESEL : ST_HIGH;
            ST_DESEL: if (tmr_done) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // Each new phase reloads the timer with its own length.
    always_comb begin
        tmr_load = (state_nxt != state);
        unique case (state_nxt)
            ST_HIGH:  tmr_val = TMR_W'(HI_EFF);
            ST_DESEL: tmr_val = TMR_W'(gap_q);
            default:  tmr_val = TMR_W'(LO_EFF);
        endcase
    end

    assign accept    = (state == ST_IDLE) && start;
    assign rise_edge = (state_nxt == ST_HIGH) && (state != ST_HIGH);
    assign frame_end = (state == ST_DESEL) && tmr_done;

    // Frame shift register and bit counter: shift on each falling edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
            gap_q     <= GAP_W'(1);
            cnt_q     <= CNT_W'(1);
            rb_q      <= 1'b0;
        end else if (accept) begin
            shreg     <= frame_img;
            bits_left <= BIT_W'(int'(cnt_eff) * WORD_W);
            gap_q     <= gap_eff;
            cnt_q     <= cnt_eff;
            rb_q      <= readback_en;
        end else if ((state == ST_HIGH) && tmr_done) begin
            shreg     <= {shreg[FRAME_W-2:0], 1'b0};
            bits_left <= bits_left - BIT_W'(1);
        end
    end

    // Registered pin outputs, decoded from the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_n_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            sclk_q <= (state_nxt == ST_HIGH);
            cs_n_q <= !((state_nxt == ST_LEAD) || (state_nxt == ST_HIGH) ||
                        (state_nxt == ST_LOW));
            done_q <= frame_end;
        end
    end

    chain_readback_check #(
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_rb (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (accept),
        .bit_strobe  (rise_edge),
        .sdo_bit     (shreg[FRAME_W-1]),
        .sdi_bit     (sdi),
        .frame_end   (frame_end),
        .rb_en       (rb_q),
        .count       (cnt_q),
        .mismatch    (mismatch)
    );

    assign sclk = sclk_q;
    assign cs_n = cs_n_q;
    assign sdo  = shreg[FRAME_W-1];
    assign busy = (state != ST_IDLE);
    assign done = done_q;

endmodule

// File: rtl/dac_chain_writer_checker.sv
module dac_chain_writer_checker #(
    parameter int HI_CYC = 4,
    parameter int LO_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic sdo,
    input logic cs_n,
    input logic busy,
    input logic done,
    input logic mismatch
);

    logic [7:0] hi_run;
    logic [7:0] lo_run;

    // Phase-length counters, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= sclk ? ((hi_run == 8'hFF) ? hi_run : hi_run + 8'd1) : 8'd0;
            lo_run <= (!sclk && !cs_n) ? ((lo_run == 8'hFF) ? lo_run : lo_run + 8'd1) : 8'd0;
        end
    end

    // R4: high phase length
    p_high_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && $past(sclk)) |-> (int'(hi_run) >= HI_CYC));

    // R4: low phase length before each rising edge
    p_low_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !$past(sclk)) |-> (int'(lo_run) >= LO_CYC));

    // R4: data holds while the clock is high
    p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdo));

    // R5: chip select moves only with the clock low
    p_cs_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n) |-> (!sclk && !$past(sclk)));

    // R5: clock parked low while deselected
    p_park_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R6: done is a single pulse in idle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n));

    // R7: accepted start raises busy
    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8: readback result only moves at the end of a frame
    p_mismatch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mismatch) |-> done);

endmodule

bind dac_chain_writer dac_chain_writer_checker #(
    .HI_CYC (HI_CYC),
    .LO_CYC (LO_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sclk     (sclk),
    .sdo      (sdo),
    .cs_n     (cs_n),
    .busy     (busy),
    .done     (done),
    .mismatch (mismatch)
);

// File: tb/dac_chain_writer_tb.sv
`timescale 1ns/1ps
module dac_chain_writer_tb;

    localparam int HI = 4;
    localparam int LO = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  dev_count = 4'd1;
    logic [79:0] codes = '0;
    logic [7:0]  desel_min = 8'd3;
    logic        readback_en = 1'b0;
    logic        sdi;
    logic        sclk, sdo, cs_n, busy, done, mismatch;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    dac_chain_writer #(
        .MAX_DEV (8),
        .HI_CYC  (HI),
        .LO_CYC  (LO),
        .GAP_W   (8)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dev_count   (dev_count),
        .codes       (codes),
        .desel_min   (desel_min),
        .readback_en (readback_en),
        .sdi         (sdi),
        .sclk        (sclk),
        .sdo         (sdo),
        .cs_n        (cs_n),
        .busy        (busy),
        .done        (done),
        .mismatch    (mismatch)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    // Receiver: bits on rising sclk, windows on falling cs_n.
    logic [127:0] rx_bits = '0;
    int           rx_n = 0;
    int           windows = 0;
    always @(negedge cs_n) begin
        rx_bits = '0;
        rx_n    = 0;
        windows = windows + 1;
    end
    always @(posedge sclk) begin
        if (!cs_n) begin
            rx_bits = {rx_bits[126:0], sdo};
            rx_n    = rx_n + 1;
        end
    end

    // Chain model: model_len bits shifted on rising sclk, far end returns on sdi.
    logic [127:0] chain = '0;
    int           model_len = 16;
    assign sdi = chain[model_len-1];
    always @(posedge sclk) begin
        if (!cs_n) chain <= {chain[126:0], sdo};
    end

    // Pin timing monitor (R4, R5, R6), sampled away from the active edge.
    int   hi_run = 0, lo_run = 0, gap_run = 1000, req_gap = 0;
    logic p_sclk = 1'b0, p_cs = 1'b1, p_sdo = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sclk && p_sclk) chk(hi_run >= HI, "R4 high phase", hi_run, HI);
            if (sclk && !p_sclk) chk(lo_run >= LO, "R4 low phase", lo_run, LO);
            if (sclk && p_sclk && (sdo != p_sdo)) chk(0, "R4 sdo moved while high", sdo, p_sdo);
            if (cs_n != p_cs) chk(!sclk && !p_sclk, "R5 cs edge with sclk low", sclk, 0);
            if (cs_n && sclk) chk(0, "R5 sclk high while deselected", sclk, 0);
            if (!cs_n && p_cs) chk(gap_run >= req_gap, "R6 deselect gap", gap_run, req_gap);
        end
        hi_run  = sclk ? hi_run + 1 : 0;
        lo_run  = (!sclk && !cs_n) ? lo_run + 1 : 0;
        gap_run = cs_n ? gap_run + 1 : 0;
        p_sclk  = sclk;
        p_cs    = cs_n;
        p_sdo   = sdo;
    end

    function automatic logic [127:0] exp_frame(input int n, input logic [79:0] cv);
        logic [127:0] e = '0;
        for (int k = 0; k < n; k++) begin
            e = (e << 16) | {112'b0, 4'b0, cv[(n-1-k)*10 +: 10], 2'b0};
        end
        return e;
    endfunction

    int           f_n, f_gap, f_t0, f_win;
    logic [127:0] f_exp;

    task automatic launch(input int n, input logic [79:0] cv, input int gap, input bit rb);
        @(negedge clk);
        dev_count   = 4'(n);
        codes       = cv;
        desel_min   = 8'(gap);
        readback_en = rb;
        start       = 1'b1;
        f_n   = (n == 0) ? 1 : ((n > 8) ? 8 : n);
        f_gap = (gap == 0) ? 1 : gap;
        f_exp = exp_frame(f_n, cv);
        f_win = windows;
        @(negedge clk);
        start = 1'b0;
        f_t0  = cyc;
        chk(busy, "R7 busy after start", busy, 1);
    endtask

    task automatic finish_frame();
        int lat;
        while (!done) @(negedge clk);
        lat = cyc - f_t0;
        chk(lat == LO + 16 * f_n * (HI + LO) + f_gap, "R9 start to done", lat,
            LO + 16 * f_n * (HI + LO) + f_gap);
        chk(!busy && cs_n, "R6 idle at done", {busy, cs_n}, 2'b01);
        chk(rx_bits == f_exp, "R2 word content", rx_bits, f_exp);
        chk(rx_n == 16 * f_n && windows == f_win + 1, "R3 bits in one window",
            rx_n, 16 * f_n);
        @(negedge clk);
        chk(!done, "R6 done one cycle", done, 0);
        req_gap = f_gap;
    endtask

    task automatic run(input int n, input logic [79:0] cv, input int gap, input bit rb);
        launch(n, cv, gap, rb);
        finish_frame();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk({cs_n, sclk, sdo, busy, done, mismatch} == 6'b100000, "R1 in reset",
            {cs_n, sclk, sdo, busy, done, mismatch}, 6'b100000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({cs_n, sclk, sdo, busy, done, mismatch} == 6'b100000, "R1 after reset",
            {cs_n, sclk, sdo, busy, done, mismatch}, 6'b100000);
    endtask

    task automatic t_single();
        logic [79:0] cv = '0;
        cv[9:0] = 10'h2A5;
        run(1, cv, 3, 0);
    endtask

    task automatic t_chain4();
        logic [79:0] cv = '0;
        cv[39:0] = {10'h3C1, 10'h155, 10'h0F0, 10'h201};
        run(4, cv, 2, 0);
    endtask

    task automatic t_full8();
        logic [79:0] cv;
        for (int d = 0; d < 8; d++) cv[d*10 +: 10] = 10'(d * 113 + 7);
        run(8, cv, 3, 0);
        run(8, {8{10'h3FF}}, 1, 0);
    endtask

    task automatic t_clamp();
        logic [79:0] cv;
        for (int d = 0; d < 8; d++) cv[d*10 +: 10] = 10'(1023 - d * 37);
        run(0, cv, 2, 0);   // R3: count 0 behaves as 1
        run(12, cv, 2, 0);  // R3: count above 8 behaves as 8
    endtask

    task automatic t_busy();
        logic [79:0] cv = '0;
        int w;
        cv[19:0] = {10'h1AA, 10'h055};
        launch(2, cv, 3, 0);
        repeat (60) @(negedge clk);
        codes     = {8{10'h3FF}};
        dev_count = 4'd5;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_frame();
        w = windows;
        repeat (40) @(negedge clk);
        chk(windows == w && cs_n && !busy, "R7 start while busy ignored", windows, w);
    endtask

    task automatic t_gap();
        logic [79:0] cv = '0;
        cv[9:0] = 10'h133;
        run(1, cv, 9, 0);
        run(1, cv, 0, 0);   // R6: zero gap behaves as one cycle
    endtask

    task automatic t_readback();
        logic [79:0] cv = '0;
        cv[19:0] = {10'h2C3, 10'h1E7};
        model_len = 32;
        run(2, cv, 2, 0);
        run(2, cv, 2, 1);
        chk(!mismatch, "R8 clean readback", mismatch, 0);
        chain[5] = ~chain[5];
        run(2, cv, 2, 1);
        chk(mismatch, "R8 corrupted readback", mismatch, 1);
        run(2, cv, 2, 0);
        chk(mismatch, "R8 held without readback", mismatch, 1);
        run(3, cv, 2, 1);
        chk(!mismatch, "R8 count changed", mismatch, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_chain4();
        t_full8();
        t_clamp();
        t_busy();
        t_gap();
        t_readback();
        finished = 1;
        summary();
        $finish;
    end

endmodule